// File: doc/BRIEF.md
# Data Address Check and Breakpoint Unit

This block sits in the load/store path and inspects each data address before it goes to memory. It takes its settings from the system control register file: the process-ID register, the control register, the two data breakpoint registers, the breakpoint control register and the debug status register. From these it does three things. It relocates low addresses into the current process slot. It flags misaligned accesses as data aborts and produces the fault status and fault address updates. It matches the address against the breakpoints and, on a hit, raises a trap and produces a debug status update.

Each breakpoint has a 2-bit direction code, so it can watch stores, loads or both. A mode bit changes how the second breakpoint register is used. Normally it is a second word-granular comparator. In mask mode it becomes an inverse mask: every bit set in it is a don't-care bit when the first breakpoint compares the address.

All results come out of one register stage. Each result is valid in the cycle after the cycle in which `req_valid_i` was sampled high.

Top module: `dacc_bkpt_unit`

## Requirements
- R1: When the process-ID field (`cfg_pid_i[31:25]`) is non-zero and `req_addr_i[31:25]` is all zero, `addr_o` carries the address with that field placed in bits 31:25. Otherwise `addr_o` equals `req_addr_i`. The low 25 bits always pass through unchanged.
- R2: When the alignment enable (`cfg_ctrl_i[1]`) is set and address bits 1:0 are non-zero, the unit does all of the following: it pulses `abort_o`, `fsr_we_o` and `far_we_o`; it drives `fsr_wdata_o` to 32'h0000_0400; and it drives `far_wdata_o` to the relocated address. With the enable clear, or with an aligned address, no abort is raised.
- R3: The direction code is `cfg_bpctl_i[1:0]` for breakpoint 0 and `cfg_bpctl_i[3:2]` for breakpoint 1. Code 0 disables the breakpoint, 1 matches stores only, 2 matches both directions and 3 matches loads only. `req_store_i` = 1 marks a store.
- R4: When the mask mode bit (`cfg_bpctl_i[8]`) is set, a hit requires (addr AND NOT bp1) == (bp0 AND NOT bp1) under breakpoint 0's direction code. Breakpoint 1's own code is ignored in this mode.
- R5: When the mask mode bit is clear, each breakpoint compares address bits 31:2 with its register, and address bits 1:0 are ignored. Breakpoint 1 uses its own code from bits 3:2.
- R6: While `cfg_dsr_i[31]` is set, no trap is raised. On a trap, `dsr_we_o` pulses and `dsr_wdata_o` equals `cfg_dsr_i` with bits 4:2 replaced by 3'b010.
- R7: Each result is registered and appears exactly one cycle after the sampled access. A cycle with no valid access produces no abort, no trap and no strobe. An access that hits both breakpoints produces a single trap.
- R8: After an active-low reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A data access is presented this cycle |
| req_addr_i | input | 32 | Virtual data address |
| req_store_i | input | 1 | 1 = store, 0 = load |
| cfg_pid_i | input | 32 | Process-ID register; bits 31:25 are used |
| cfg_ctrl_i | input | 32 | Control register; bit 1 enables alignment checking |
| cfg_bp0_i | input | 32 | Data breakpoint 0 address |
| cfg_bp1_i | input | 32 | Data breakpoint 1 address, or the inverse mask in mask mode |
| cfg_bpctl_i | input | 32 | Breakpoint control: direction codes in bits 1:0 and 3:2, mask mode in bit 8 |
| cfg_dsr_i | input | 32 | Debug status register; bit 31 suppresses traps |
| addr_valid_o | output | 1 | `addr_o` holds a new access |
| addr_o | output | 32 | Relocated address |
| abort_o | output | 1 | Data abort pulse |
| trap_o | output | 1 | Breakpoint trap pulse |
| fsr_we_o | output | 1 | Fault status write strobe |
| fsr_wdata_o | output | 32 | Fault status write value |
| far_we_o | output | 1 | Fault address write strobe |
| far_wdata_o | output | 32 | Fault address write value |
| dsr_we_o | output | 1 | Debug status write strobe |
| dsr_wdata_o | output | 32 | Debug status write value |

## Verification
Every output of this block is due one cycle after the access. This covers the relocated address, the abort with its fault status and fault address strobes, and the trap with its debug status strobe. The bench applies each access on a falling edge and computes the expected outputs from the same inputs. It compares them on the next falling edge, after exactly one rising edge has passed. Between accesses it inserts idle cycles that hold a misaligned, matching address with `req_valid_i` low. The outputs sampled there must show that the pulses lasted only one cycle and that idle inputs are ignored.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  typedef enum logic [1:0] {
    BP_OFF = 2'd0,
    BP_ST  = 2'd1,
    BP_ANY = 2'd2,
    BP_LD  = 2'd3
  } bp_dir_e;

  function automatic logic dir_ok(bp_dir_e en, logic is_store);
    return (en != BP_OFF) && (is_store ? (en != BP_LD) : (en != BP_ST));
  endfunction
endpackage

// File: rtl/dacc_reloc.sv
module dacc_reloc #(
  parameter int AW    = 32,
  parameter int TAG_W = 7
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic [AW-1:0]    addr_o
);
  localparam int LOW_W = AW - TAG_W;

  logic in_low;
  assign in_low = (addr_i[AW-1:LOW_W] == '0);

  always_comb begin
    addr_o = addr_i;
    if (in_low && (tag_i != '0)) addr_o[AW-1:LOW_W] = tag_i;
  end
endmodule

// File: rtl/dacc_align.sv
module dacc_align #(
  parameter int AW        = 32,
  parameter int GRAN_BITS = 2
) (
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  output logic          fault_o
);
  assign fault_o = en_i && (addr_i[GRAN_BITS-1:0] != '0);
endmodule

// File: rtl/dacc_bp_cmp.sv
module dacc_bp_cmp
  import dacc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] ref_i,
  input  logic [AW-1:0] care_i,
  input  bp_dir_e       en_i,
  input  logic          store_i,
  output logic          hit_o
);
  logic addr_eq;
  assign addr_eq = ((addr_i & care_i) == (ref_i & care_i));
  assign hit_o   = addr_eq && dir_ok(en_i, store_i);
endmodule

// File: rtl/dacc_bkpt_unit.sv
module dacc_bkpt_unit
  import dacc_pkg::*;
#(
  parameter int          AW            = 32,
  parameter int          TAG_W         = 7,
  parameter int          GRAN_BITS     = 2,
  parameter int          ALIGN_EN_BIT  = 1,
  parameter int          MASK_MODE_BIT = 8,
  parameter int          HALT_BIT      = 31,
  parameter int          MOE_LSB       = 2,
  parameter int          MOE_W         = 3,
  parameter logic [2:0]  MOE_DBKPT     = 3'd2,
  parameter logic [31:0] FSR_ALIGN     = 32'h0000_0400
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_store_i,
  input  logic [AW-1:0] cfg_pid_i,
  input  logic [AW-1:0] cfg_ctrl_i,
  input  logic [AW-1:0] cfg_bp0_i,
  input  logic [AW-1:0] cfg_bp1_i,
  input  logic [AW-1:0] cfg_bpctl_i,
  input  logic [AW-1:0] cfg_dsr_i,
  output logic          addr_valid_o,
  output logic [AW-1:0] addr_o,
  output logic          abort_o,
  output logic          trap_o,
  output logic          fsr_we_o,
  output logic [AW-1:0] fsr_wdata_o,
  output logic          far_we_o,
  output logic [AW-1:0] far_wdata_o,
  output logic          dsr_we_o,
  output logic [AW-1:0] dsr_wdata_o
);
  localparam int              NUM_BP    = 2;
  localparam int              EN_W      = 2;
  localparam logic [AW-1:0]   WORD_CARE = {{(AW-GRAN_BITS){1'b1}}, {GRAN_BITS{1'b0}}};
  localparam logic [AW-1:0]   MOE_FIELD = AW'(((1 << MOE_W) - 1) << MOE_LSB);
  localparam logic [AW-1:0]   MOE_VAL   = AW'(MOE_DBKPT) << MOE_LSB;

  logic [AW-1:0] addr_rel;
  logic          misalign;
  logic          mask_mode;
  logic [AW-1:0] bp_ref [NUM_BP];
  logic [NUM_BP-1:0] bp_hit;
  logic          abort_d, trap_d;

  dacc_reloc #(.AW(AW), .TAG_W(TAG_W)) u_reloc (
    .addr_i (req_addr_i),
    .tag_i  (cfg_pid_i[AW-1 -: TAG_W]),
    .addr_o (addr_rel)
  );

  dacc_align #(.AW(AW), .GRAN_BITS(GRAN_BITS)) u_align (
    .en_i    (cfg_ctrl_i[ALIGN_EN_BIT]),
    .addr_i  (addr_rel),
    .fault_o (misalign)
  );

  assign mask_mode = cfg_bpctl_i[MASK_MODE_BIT];
  assign bp_ref[0] = cfg_bp0_i;
  assign bp_ref[1] = cfg_bp1_i;

  for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
    logic [AW-1:0] care;
    bp_dir_e       en;
    if (g == 0) begin : g_lead
      // bp1 becomes an inverse mask for bp0
      assign care = mask_mode ? ~cfg_bp1_i : WORD_CARE;
      assign en   = bp_dir_e'(cfg_bpctl_i[EN_W*g +: EN_W]);
    end else begin : g_follow
      assign care = WORD_CARE;
      assign en   = mask_mode ? BP_OFF : bp_dir_e'(cfg_bpctl_i[EN_W*g +: EN_W]);
    end
    dacc_bp_cmp #(.AW(AW)) u_cmp (
      .addr_i  (addr_rel),
      .ref_i   (bp_ref[g]),
      .care_i  (care),
      .en_i    (en),
      .store_i (req_store_i),
      .hit_o   (bp_hit[g])
    );
  end

  assign abort_d = req_valid_i && misalign;
  assign trap_d  = req_valid_i && !cfg_dsr_i[HALT_BIT] && (|bp_hit);

  logic          valid_q, abort_q, trap_q;
  logic [AW-1:0] addr_q, far_q, dsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      abort_q <= 1'b0;
      trap_q  <= 1'b0;
      addr_q  <= '0;
      far_q   <= '0;
      dsr_q   <= '0;
    end else begin
      valid_q <= req_valid_i;
      abort_q <= abort_d;
      trap_q  <= trap_d;
      if (req_valid_i) addr_q <= addr_rel;
      if (abort_d)     far_q  <= addr_rel;
      if (trap_d)      dsr_q  <= (cfg_dsr_i & ~MOE_FIELD) | MOE_VAL;
    end
  end

  assign addr_valid_o = valid_q;
  assign addr_o       = addr_q;
  assign abort_o      = abort_q;
  assign trap_o       = trap_q;
  assign fsr_we_o     = abort_q;
  assign fsr_wdata_o  = abort_q ? AW'(FSR_ALIGN) : '0;
  assign far_we_o     = abort_q;
  assign far_wdata_o  = far_q;
  assign dsr_we_o     = trap_q;
  assign dsr_wdata_o  = dsr_q;
endmodule

// File: rtl/dacc_bkpt_chk.sv
module dacc_bkpt_chk #(
  parameter int AW            = 32,
  parameter int TAG_W         = 7,
  parameter int GRAN_BITS     = 2,
  parameter int MASK_MODE_BIT = 8,
  parameter int HALT_BIT      = 31,
  parameter int MOE_LSB       = 2,
  parameter int MOE_W         = 3,
  parameter logic [2:0] MOE_DBKPT = 3'd2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [AW-1:0] req_addr_i,
  input logic [AW-1:0] cfg_bpctl_i,
  input logic [AW-1:0] cfg_dsr_i,
  input logic          addr_valid_o,
  input logic [AW-1:0] addr_o,
  input logic          abort_o,
  input logic          trap_o,
  input logic          far_we_o,
  input logic [AW-1:0] far_wdata_o,
  input logic          dsr_we_o,
  input logic [AW-1:0] dsr_wdata_o
);
  localparam int LOW_W = AW - TAG_W;

  AST_RELOC_LOW_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> addr_o[LOW_W-1:0] == $past(req_addr_i[LOW_W-1:0])); // R1
  AST_ABORT_MISALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(req_addr_i[GRAN_BITS-1:0]) != '0); // R2
  AST_FAR_IS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    far_we_o |-> far_wdata_o == addr_o); // R2
  AST_DIR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_valid_i && !cfg_bpctl_i[MASK_MODE_BIT] && cfg_bpctl_i[3:0] == 4'd0) |-> !trap_o); // R3
  AST_MASK_BP1_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_valid_i && cfg_bpctl_i[MASK_MODE_BIT] && cfg_bpctl_i[1:0] == 2'd0) |-> !trap_o); // R4
  AST_HALT_NO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_valid_i && cfg_dsr_i[HALT_BIT]) |-> !trap_o); // R6
  AST_DSR_MOE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsr_we_o |-> (dsr_wdata_o[MOE_LSB +: MOE_W] == MOE_DBKPT) && !dsr_wdata_o[HALT_BIT]); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_valid_i) |-> !abort_o && !trap_o && !dsr_we_o && !far_we_o); // R7
  AST_TRAP_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trap_o) |-> dsr_we_o); // R6
endmodule

bind dacc_bkpt_unit dacc_bkpt_chk #(
  .AW(AW), .TAG_W(TAG_W), .GRAN_BITS(GRAN_BITS), .MASK_MODE_BIT(MASK_MODE_BIT),
  .HALT_BIT(HALT_BIT), .MOE_LSB(MOE_LSB), .MOE_W(MOE_W), .MOE_DBKPT(MOE_DBKPT)
) u_chk (.*);

// File: tb/dacc_bkpt_unit_tb_top.sv
`timescale 1ns/1ps
module dacc_bkpt_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        req_store_i = 1'b0;
  logic [31:0] cfg_pid_i = '0, cfg_ctrl_i = '0, cfg_bp0_i = '0, cfg_bp1_i = '0;
  logic [31:0] cfg_bpctl_i = '0, cfg_dsr_i = '0;
  logic        addr_valid_o, abort_o, trap_o, fsr_we_o, far_we_o, dsr_we_o;
  logic [31:0] addr_o, fsr_wdata_o, far_wdata_o, dsr_wdata_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  dacc_bkpt_unit dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] reloc(logic [31:0] a, logic [31:0] pid);
    return (pid[31:25] != 0 && a[31:25] == 0) ? {pid[31:25], a[24:0]} : a;
  endfunction

  function automatic logic dir(logic [1:0] c, logic st);
    return c != 0 && (st ? c != 3 : c != 1);
  endfunction

  // Apply one access at a falling edge, check at the next falling edge.
  task automatic access(logic [31:0] a, logic st, logic [31:0] pid, logic [31:0] ctl,
                        logic [31:0] b0, logic [31:0] b1, logic [31:0] bc, logic [31:0] dsr,
                        string tag);
    logic [31:0] ra;
    logic ab, h0, h1, tr;
    req_valid_i = 1; req_addr_i = a; req_store_i = st; cfg_pid_i = pid; cfg_ctrl_i = ctl;
    cfg_bp0_i = b0; cfg_bp1_i = b1; cfg_bpctl_i = bc; cfg_dsr_i = dsr;
    ra = reloc(a, pid);
    ab = ctl[1] && ra[1:0] != 0;
    if (bc[8]) begin
      h0 = dir(bc[1:0], st) && ((ra & ~b1) == (b0 & ~b1));
      h1 = 0;
    end else begin
      h0 = dir(bc[1:0], st) && (ra[31:2] == b0[31:2]);
      h1 = dir(bc[3:2], st) && (ra[31:2] == b1[31:2]);
    end
    tr = !dsr[31] && (h0 || h1);
    @(negedge clk_i);
    chk({tag, " R1 addr"}, addr_o, ra);
    chk({tag, " R7 valid"}, {31'b0, addr_valid_o}, 32'd1);
    chk({tag, " R2 abort"}, {29'b0, abort_o, fsr_we_o, far_we_o}, {29'b0, ab, ab, ab});
    if (ab) begin
      chk({tag, " R2 fsr"}, fsr_wdata_o, 32'h0000_0400);
      chk({tag, " R2 far"}, far_wdata_o, ra);
    end
    chk({tag, " R3 trap"}, {30'b0, trap_o, dsr_we_o}, {30'b0, tr, tr});
    if (tr) chk({tag, " R6 dsr"}, dsr_wdata_o, {dsr[31:5], 3'b010, dsr[1:0]});
  endtask

  // Idle cycle holding a misaligned hitting address: no pulse may appear.
  task automatic idle();
    req_valid_i = 0; req_addr_i = 32'h0000_1003; req_store_i = 1;
    cfg_ctrl_i = 32'h2; cfg_bp0_i = 32'h0000_1000; cfg_bpctl_i = 32'h2; cfg_dsr_i = 0;
    @(negedge clk_i);
    chk("R7 idle quiet", {28'b0, abort_o, trap_o, dsr_we_o, addr_valid_o}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk_i);
    chk("R8 reset", {26'b0, addr_valid_o, abort_o, trap_o, fsr_we_o, far_we_o, dsr_we_o}, 0);
    chk("R8 reset addr", addr_o | far_wdata_o | dsr_wdata_o | fsr_wdata_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 relocation
    access(32'h0000_1000, 0, 32'hFE00_0000, 0, 0, 0, 0, 0, "R1 low");
    access(32'h0200_1000, 0, 32'hFE00_0000, 0, 0, 0, 0, 0, "R1 high");
    access(32'h0000_1000, 0, 32'h01FF_FFFF, 0, 0, 0, 0, 0, "R1 pidzero");
    // R2 alignment
    access(32'h0000_2002, 0, 0, 32'h0, 0, 0, 0, 0, "R2 off");
    access(32'h0000_2002, 0, 32'h0400_0000, 32'h2, 0, 0, 0, 0, "R2 on");
    access(32'h0000_2004, 1, 0, 32'h2, 0, 0, 0, 0, "R2 aligned");
    // R3 direction codes on bp0
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 2; s++)
        access(32'h0000_1000, 1'(s), 0, 0, 32'h0000_1000, 32'hFFFF_0000, 32'(c), 0, "R3 dir");
    // R5 low bits ignored, bp1 own code
    access(32'h0000_1003, 0, 0, 0, 32'h0000_1000, 0, 32'h2, 0, "R5 lsb");
    access(32'h0000_5001, 1, 0, 0, 0, 32'h0000_5000, 32'h4, 0, "R5 bp1 st");
    access(32'h0000_5001, 0, 0, 0, 0, 32'h0000_5000, 32'h4, 0, "R5 bp1 ld");
    // R4 mask mode
    access(32'h1234_ABCD, 0, 0, 0, 32'h1234_0000, 32'h0000_FFFF, 32'h102, 0, "R4 hit");
    access(32'h1235_ABCD, 0, 0, 0, 32'h1234_0000, 32'h0000_FFFF, 32'h102, 0, "R4 miss");
    access(32'h0000_FFFF, 0, 0, 0, 32'h1234_0000, 32'h0000_FFFF, 32'h108, 0, "R4 bp1 ign");
    // R6 halt and dsr contents
    access(32'h0000_1000, 0, 0, 0, 32'h0000_1000, 0, 32'h2, 32'h8000_0000, "R6 halt");
    access(32'h0000_1000, 0, 0, 0, 32'h0000_1000, 0, 32'h2, 32'h7FFF_FFFF, "R6 keep");
    // R7 both hit, back to back, then idle
    access(32'h0000_1000, 1, 0, 32'h2, 32'h0000_1000, 32'h0000_1000, 32'hA, 0, "R7 both");
    access(32'h0000_1001, 1, 0, 32'h2, 32'h0000_1000, 32'h0000_1000, 32'hA, 0, "R7 b2b");
    idle();
    // random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, pid, b0, b1, bc, dsr;
      b0 = $urandom; b1 = $urandom;
      pid = ($urandom % 2) ? 0 : $urandom;
      bc = {23'b0, 1'($urandom), 4'b0, 4'($urandom)};
      if (bc[8]) b1 = $urandom % 2 ? 32'h0000_0FFF : 32'h00FF_00F3;
      case ($urandom % 4)
        0: a = $urandom;
        1: a = {b0[31:2], 2'($urandom)};
        2: a = bc[8] ? (b0 ^ ($urandom & b1)) : {b1[31:2], 2'($urandom)};
        default: a = {7'b0, 25'($urandom)};
      endcase
      if (a[31:25] == 0 && $urandom % 2) pid = 0;
      dsr = $urandom; dsr[31] = ($urandom % 4 == 0);
      access(a, 1'($urandom), pid, $urandom, b0, b1, bc, dsr, "rand");
      if ($urandom % 8 == 0) idle();
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule